// File: doc/BRIEF.md
# Selectable Hardware/Software Clock Gate

This block decides whether a clock branch runs. The decision comes from one of two owners: an automatic hardware request input, or a software enable bit held in a 32-bit control word. A mode bit in the same word picks the owner. Software reaches the word through a plain write strobe with write data and a continuously driven read word. The block drives a clock-enable output and reports the gate state that has actually taken effect in a read-only status bit. That bit trails the enable by a fixed two-cycle synchronising delay, so software can poll it until a change it asked for has completed.

A build-time parameter picks one of five flavours. With no gate, the clock always runs. With hardware only, the request input alone decides. With software only, the enable bit alone decides. In selectable mode, the owner bit chooses between the request and the enable. Selectable with no disable works like selectable, except that under software ownership the clock always runs, because software may turn it on but never off. Each bit position is a parameter. The defaults are: enable at bit 0, owner select at bit 1, status at bit 2.

Top module: `clk_gate_ctl`

## Requirements
- R1: While reset is high, a selectable gate (either selectable flavour) reads back owner=1 and enable=1 with status=0, and drives the clock enable high. A software-only gate reads enable=1 and drives the enable high.
- R2: In a selectable flavour with owner bit (bit 1) at 0, the clock enable equals the hardware request input in the same cycle.
- R3: With owner bit 1 (selectable), or in the software-only flavour, the clock enable equals the enable bit (bit 0: 1 runs, 0 stops), and the hardware request has no effect.
- R4: The status bit (bit 2) equals the clock enable as it was two clock cycles earlier.
- R5: The flavour with no gate keeps the clock enable high at all times and reads back an all-zero word.
- R6: The hardware-only flavour drives the clock enable from the request input alone, ignores all writes, and reads back only the status bit.
- R7: In the no-disable flavour, the clock enable is high whenever the owner bit is 1, and the enable bit always reads 1, whatever is written to it.
- R8: Bits that the flavour does not implement ignore writes and read as 0. Only bits 0 to 2 can ever read as 1.
- R9: The status bit cannot be written. Writing either value to bit 2 leaves it reporting the gate state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| hw_req | input | 1 | Hardware clock request (auto-gating) |
| rd_data | output | 32 | Control word read-back, including status |
| clk_en_o | output | 1 | Gate enable for the clock branch |

## Verification
The assertions check on every cycle that the enable follows whichever owner the read-back word shows, that the no-disable flavour runs under software ownership, that the status bit equals the enable of two cycles earlier, and that unimplemented bits stay zero. Some behaviour only the bench's scenarios can show. This covers the reset-state values, the fact that writes really change the owner and enable fields, the intermediate lagging status values software would poll, and the way a write that sets the status bit has no effect. The bench drives the same write and request sequence into all five flavours and compares each one against values worked out from the requirements.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    localparam int unsigned CTL_W = 32;

    typedef enum logic [2:0] {
        GATE_ABSENT      = 3'd0,
        GATE_HW_ONLY     = 3'd1,
        GATE_SW_ONLY     = 3'd2,
        GATE_HW_SW       = 3'd3,
        GATE_HW_SW_NODIS = 3'd4
    } gate_kind_e;

    typedef struct packed {
        logic sw_owner;   // 1: software decides, 0: hardware request decides
        logic sw_enable;  // software run request
    } gate_ctl_t;

    function automatic logic kind_has_sel(gate_kind_e k);
        return (k == GATE_HW_SW) || (k == GATE_HW_SW_NODIS);
    endfunction

    function automatic logic kind_has_en(gate_kind_e k);
        return (k == GATE_SW_ONLY) || kind_has_sel(k);
    endfunction

    function automatic logic kind_has_stat(gate_kind_e k);
        return k != GATE_ABSENT;
    endfunction

    function automatic logic [CTL_W-1:0] kind_mask(gate_kind_e k, int sel_b, int en_b, int st_b);
        logic [CTL_W-1:0] m;
        m = '0;
        if (kind_has_sel(k))  m[sel_b] = 1'b1;
        if (kind_has_en(k))   m[en_b]  = 1'b1;
        if (kind_has_stat(k)) m[st_b]  = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/gate_ctl_reg.sv
module gate_ctl_reg
    import clkgate_pkg::*;
#(
    parameter gate_kind_e KIND = GATE_HW_SW
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      wr_owner,
    input  logic      wr_enable,
    output gate_ctl_t ctl
);

    // Owner field: stored only in selectable flavours
    if (kind_has_sel(KIND)) begin : g_owner
        logic owner_q;
        always_ff @(posedge clk) begin
            if (rst)        owner_q <= 1'b1;
            else if (wr_en) owner_q <= wr_owner;
        end
        assign ctl.sw_owner = owner_q;
    end else begin : g_owner_fixed
        assign ctl.sw_owner = (KIND == GATE_SW_ONLY);
    end

    // Enable field: stuck at one when software may not disable
    if (kind_has_en(KIND) && (KIND != GATE_HW_SW_NODIS)) begin : g_enable
        logic enable_q;
        always_ff @(posedge clk) begin
            if (rst)        enable_q <= 1'b1;
            else if (wr_en) enable_q <= wr_enable;
        end
        assign ctl.sw_enable = enable_q;
    end else begin : g_enable_fixed
        assign ctl.sw_enable = (KIND == GATE_HW_SW_NODIS);
    end

endmodule

// File: rtl/gate_decide.sv
module gate_decide
    import clkgate_pkg::*;
#(
    parameter gate_kind_e KIND = GATE_HW_SW
) (
    input  gate_ctl_t ctl,
    input  logic      hw_req,
    output logic      run
);

    always_comb begin
        unique case (KIND)
            GATE_ABSENT:      run = 1'b1;
            GATE_HW_ONLY:     run = hw_req;
            GATE_SW_ONLY:     run = ctl.sw_enable;
            GATE_HW_SW:       run = ctl.sw_owner ? ctl.sw_enable : hw_req;
            GATE_HW_SW_NODIS: run = ctl.sw_owner ? 1'b1 : hw_req;
            default:          run = 1'b1;
        endcase
    end

endmodule

// File: rtl/gate_status_pipe.sv
module gate_status_pipe #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic seen
);

    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-2:0], run};
    end

    assign seen = pipe_q[STAGES-1];

endmodule

// File: rtl/clk_gate_ctl.sv
module clk_gate_ctl
    import clkgate_pkg::*;
#(
    parameter gate_kind_e  KIND        = GATE_HW_SW,
    parameter int unsigned EN_BIT      = 0,
    parameter int unsigned SEL_BIT     = 1,
    parameter int unsigned STAT_BIT    = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             hw_req,
    output logic [CTL_W-1:0] rd_data,
    output logic             clk_en_o
);

    gate_ctl_t ctl;
    logic      run;
    logic      seen;

    gate_ctl_reg #(.KIND(KIND)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_owner  (wr_data[SEL_BIT]),
        .wr_enable (wr_data[EN_BIT]),
        .ctl       (ctl)
    );

    gate_decide #(.KIND(KIND)) u_decide (
        .ctl    (ctl),
        .hw_req (hw_req),
        .run    (run)
    );

    gate_status_pipe #(.STAGES(SYNC_STAGES)) u_stat (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .seen (seen)
    );

    always_comb begin
        rd_data = '0;
        if (kind_has_sel(KIND))  rd_data[SEL_BIT]  = ctl.sw_owner;
        if (kind_has_en(KIND))   rd_data[EN_BIT]   = ctl.sw_enable;
        if (kind_has_stat(KIND)) rd_data[STAT_BIT] = seen;
    end

    assign clk_en_o = run;

endmodule

// File: rtl/clk_gate_ctl_chk.sv
module clk_gate_ctl_chk
    import clkgate_pkg::*;
#(
    parameter gate_kind_e  KIND        = GATE_HW_SW,
    parameter int unsigned EN_BIT      = 0,
    parameter int unsigned SEL_BIT     = 1,
    parameter int unsigned STAT_BIT    = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [CTL_W-1:0] wr_data,
    input logic             hw_req,
    input logic [CTL_W-1:0] rd_data,
    input logic             clk_en_o
);

    localparam logic [CTL_W-1:0] LIVE = kind_mask(KIND, SEL_BIT, EN_BIT, STAT_BIT);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R8: unimplemented bits read as zero
    p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~LIVE) == '0);

    if (KIND == GATE_ABSENT) begin : g_absent
        p_always_on_r5: assert property (@(posedge clk) disable iff (rst)
            clk_en_o && (rd_data == '0));
    end

    if (KIND == GATE_HW_ONLY) begin : g_hw
        p_hw_follow_r6: assert property (@(posedge clk) disable iff (rst)
            clk_en_o == hw_req);
    end

    if (KIND == GATE_SW_ONLY) begin : g_sw
        p_sw_follow_r3: assert property (@(posedge clk) disable iff (rst)
            clk_en_o == rd_data[EN_BIT]);
    end

    if (KIND == GATE_HW_SW) begin : g_sel
        p_sw_owner_r3: assert property (@(posedge clk) disable iff (rst)
            rd_data[SEL_BIT] |-> (clk_en_o == rd_data[EN_BIT]));
        p_hw_owner_r2: assert property (@(posedge clk) disable iff (rst)
            !rd_data[SEL_BIT] |-> (clk_en_o == hw_req));
    end

    if (KIND == GATE_HW_SW_NODIS) begin : g_nodis
        p_no_disable_r7: assert property (@(posedge clk) disable iff (rst)
            rd_data[SEL_BIT] |-> (clk_en_o && rd_data[EN_BIT]));
        p_hw_owner_nd_r2: assert property (@(posedge clk) disable iff (rst)
            !rd_data[SEL_BIT] |-> (clk_en_o == hw_req));
    end

    if (kind_has_stat(KIND) && SYNC_STAGES == 2) begin : g_stat
        p_status_lag_r4: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2) |-> (rd_data[STAT_BIT] == $past(clk_en_o, 2)));
    end

endmodule

bind clk_gate_ctl clk_gate_ctl_chk #(
    .KIND(KIND), .EN_BIT(EN_BIT), .SEL_BIT(SEL_BIT),
    .STAT_BIT(STAT_BIT), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/tb_clk_gate_ctl.sv
`timescale 1ns/1ps
module tb_clk_gate_ctl;
    import clkgate_pkg::*;

    typedef struct {
        string       tag;
        int          idx;
        logic [31:0] rd;
        logic        en;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        hw_req = 1'b0;
    logic [31:0] rd_v [5];
    logic        en_v [5];

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    // index: 0 none, 1 hw-only, 2 sw-only, 3 selectable, 4 no-disable
    clk_gate_ctl #(.KIND(GATE_ABSENT))      u_none (.clk, .rst, .wr_en, .wr_data, .hw_req, .rd_data(rd_v[0]), .clk_en_o(en_v[0]));
    clk_gate_ctl #(.KIND(GATE_HW_ONLY))     u_hw   (.clk, .rst, .wr_en, .wr_data, .hw_req, .rd_data(rd_v[1]), .clk_en_o(en_v[1]));
    clk_gate_ctl #(.KIND(GATE_SW_ONLY))     u_sw   (.clk, .rst, .wr_en, .wr_data, .hw_req, .rd_data(rd_v[2]), .clk_en_o(en_v[2]));
    clk_gate_ctl #(.KIND(GATE_HW_SW))       dut    (.clk, .rst, .wr_en, .wr_data, .hw_req, .rd_data(rd_v[3]), .clk_en_o(en_v[3]));
    clk_gate_ctl #(.KIND(GATE_HW_SW_NODIS)) u_nd   (.clk, .rst, .wr_en, .wr_data, .hw_req, .rd_data(rd_v[4]), .clk_en_o(en_v[4]));

    task automatic expect_item(string tag, int idx, logic [31:0] rd, logic en);
        exp_t e;
        e.tag = tag; e.idx = idx; e.rd = rd; e.en = en;
        q.push_back(e);
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic write_word(logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_req(logic v);
        @(negedge clk); #1;
        hw_req = v;
        @(posedge clk); #1;
    endtask

    // monitor: compare queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (rd_v[e.idx] !== e.rd || en_v[e.idx] !== e.en) begin
                    n_bad++;
                    $display("FAIL %s flavour %0d: rd=%h en=%b expected rd=%h en=%b",
                             e.tag, e.idx, rd_v[e.idx], en_v[e.idx], e.rd, e.en);
                end
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        tick(2);
        expect_item("R1 reset", 0, 32'h0, 1'b1);
        expect_item("R1 reset", 1, 32'h0, 1'b0);
        expect_item("R1 reset", 2, 32'h1, 1'b1);
        expect_item("R1 reset", 3, 32'h3, 1'b1);
        expect_item("R1 reset", 4, 32'h3, 1'b1);
        @(negedge clk); #1; rst = 1'b0;
        tick(3);
        expect_item("R4 settled", 2, 32'h5, 1'b1);
        expect_item("R4 settled", 3, 32'h7, 1'b1);
        expect_item("R4 settled", 4, 32'h7, 1'b1);
        expect_item("R5 none", 0, 32'h0, 1'b1);

        // R3 software disable, R7 refused disable
        write_word(32'h2);
        expect_item("R3 sw off", 3, 32'h6, 1'b0);
        expect_item("R3 sw-only off", 2, 32'h4, 1'b0);
        expect_item("R7 nodis", 4, 32'h7, 1'b1);
        expect_item("R6 write ignored", 1, 32'h0, 1'b0);
        tick(1);
        expect_item("R4 status lag", 3, 32'h6, 1'b0);
        tick(1);
        expect_item("R4 status done", 3, 32'h2, 1'b0);
        expect_item("R4 status done", 2, 32'h0, 1'b0);

        // R8 all-ones write
        write_word(32'hFFFF_FFFF);
        expect_item("R8 ones", 3, 32'h3, 1'b1);
        expect_item("R8 ones", 2, 32'h1, 1'b1);
        expect_item("R8 ones", 1, 32'h0, 1'b0);
        expect_item("R8 ones", 0, 32'h0, 1'b1);
        tick(2);
        expect_item("R8 settled", 3, 32'h7, 1'b1);
        expect_item("R8 settled", 2, 32'h5, 1'b1);

        // R2 hand over to hardware
        write_word(32'h0);
        expect_item("R2 hw owner", 3, 32'h4, 1'b0);
        expect_item("R7 en stuck", 4, 32'h5, 1'b0);
        expect_item("R3 sw-only off", 2, 32'h4, 1'b0);
        tick(2);
        expect_item("R2 settled", 3, 32'h0, 1'b0);
        expect_item("R7 settled", 4, 32'h1, 1'b0);

        set_req(1'b1);
        expect_item("R2 req on", 3, 32'h0, 1'b1);
        expect_item("R2 req on", 4, 32'h1, 1'b1);
        expect_item("R6 req on", 1, 32'h0, 1'b1);
        expect_item("R3 req ignored", 2, 32'h0, 1'b0);
        tick(1);
        expect_item("R6 status", 1, 32'h4, 1'b1);
        expect_item("R4 hw status", 3, 32'h4, 1'b1);
        expect_item("R4 hw status", 4, 32'h5, 1'b1);

        // R9 writing the status bit does nothing
        write_word(32'h4);
        expect_item("R9 ro status", 3, 32'h4, 1'b1);
        expect_item("R9 ro status", 1, 32'h4, 1'b1);
        tick(3);
        expect_item("R9 ro status", 2, 32'h0, 1'b0);
        expect_item("R9 ro status", 3, 32'h4, 1'b1);

        set_req(1'b0);
        expect_item("R2 req off", 3, 32'h4, 1'b0);
        expect_item("R6 req off", 1, 32'h4, 1'b0);
        expect_item("R5 req off", 0, 32'h0, 1'b1);

        @(negedge clk); #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule